// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequence Controller

This block is the control core of a small nonvolatile SRAM model. It holds a working byte array and a shadow array of the same size. Ordinary chip-enable cycles read or write the working array. Two kinds of nonvolatile cycle exist. A STORE copies the working array into the shadow array. A RECALL copies the shadow array back into the working array.

Software starts either operation by reading a fixed, ordered list of six addresses with write-enable held high. A hardware store request arrives on an active-low input. The block keeps a "modified since last nonvolatile cycle" flag, so a store with nothing new to save is skipped. While a copy runs, or while the hardware request is still asserted afterwards, `busy_n` is low and every access is ignored.

The model is synchronous. Each rising clock edge with `ce_n` low is one access cycle. The working array has `2**ARR_AW` bytes and is indexed by the low `ARR_AW` bits of the 13-bit address. The unlock sequence compares all 13 bits. The copy moves one byte per clock. After the copy, a parameterised tail of idle busy cycles follows.

There are four states:
- IDLE: accesses allowed.
- STORE: working array copied to shadow.
- RECALL: shadow copied to working array.
- HOLD: inhibited until the hardware request is released.

The transitions are:
- IDLE→STORE: on a store unlock or a hardware request, when the flag is set.
- IDLE→HOLD: on a hardware request when the flag is clear.
- IDLE→RECALL: on a recall unlock.
- STORE→IDLE or STORE→HOLD: at the end of the copy; HOLD when the store came from hardware.
- RECALL→IDLE: at the end of the copy.
- HOLD→IDLE: when the request input is high.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset, `busy_n` is 1, `dout_en` is 0 and `dout` is 0.
- R2: In IDLE, with `hsb_n` high, a clock edge with `ce_n`=0 and `we_n`=0 writes `din` into byte `addr[ARR_AW-1:0]`. It also sets the modified flag.
- R3: A read cycle in IDLE (`ce_n`=0, `we_n`=1, `oe_n`=0) presents that byte on `dout` with `dout_en`=1 after the same edge. With `oe_n`=1 or `ce_n`=1 the block gives `dout_en`=0 and `dout`=0.
- R4: Six read cycles at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order with `we_n` high, request a STORE. Cycles with `ce_n` high between them do not count. `oe_n` has no effect on recognition, and every one of these cycles still behaves as a normal read.
- R5: The same five first addresses followed by 0x0F0E start a RECALL.
- R6: A cycle with `we_n` low, or a read at an unexpected address, returns the matcher to idle. An unexpected read at 0x0000 restarts it at step one.
- R7: `busy_n` is low for exactly `2**ARR_AW+STORE_TAIL` cycles during a STORE and `2**ARR_AW+RECALL_TAIL` cycles during a RECALL. The low period starts after the edge of the sixth read.
- R8: While `busy_n` is low, writes are dropped and reads give `dout_en`=0.
- R9: A STORE request made while the modified flag is clear is skipped: `busy_n` stays high.
- R10: A completed STORE or RECALL clears the modified flag.
- R11: `hsb_n` low in IDLE with the flag set runs a STORE. The block then holds `busy_n` low until `hsb_n` is seen high, and `busy_n` rises one cycle later.
- R12: `hsb_n` low in IDLE with the flag clear enters HOLD at once, with no copy period.
- R13: A RECALL restores every byte to the value it had at the last completed STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable; each low edge is one access |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 13 | Access address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not enabled |
| dout_en | output | 1 | Read data valid / output drive enable |
| hsb_n | input | 1 | Active-low hardware store request |
| busy_n | output | 1 | Low while a nonvolatile cycle or hold is in progress |

## Verification
A matcher left in the wrong step shows at `busy_n`. Either `busy_n` fails to fall right after a correct sixth read, or it falls after a broken sequence; both appear one cycle after the edge. A wrong modified flag shows in the same way when a store request arrives: a skipped store keeps `busy_n` high, and a needless one pulls it low. A copy that is cut short or misindexed stays hidden until the next RECALL. After that RECALL, a read of the affected byte returns a wrong value.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RECALL, ST_HOLD} nvs_state_t;

    localparam logic [ADDR_W-1:0] KEY_FIRST  = 13'h0000;
    localparam logic [ADDR_W-1:0] KEY_STORE  = 13'h0F0F;
    localparam logic [ADDR_W-1:0] KEY_RECALL = 13'h0F0E;

    // Expected address for steps 0..4 of the unlock sequence
    function automatic logic [ADDR_W-1:0] key_addr(input logic [2:0] step);
        logic [ADDR_W-1:0] a;
        unique case (step)
            3'd0:    a = KEY_FIRST;
            3'd1:    a = 13'h1555;
            3'd2:    a = 13'h0AAA;
            3'd3:    a = 13'h1FFF;
            3'd4:    a = 13'h10F0;
            default: a = KEY_FIRST;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock
    import nvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_go,
    output logic              recall_go
);
    localparam logic [2:0] LAST_STEP = 3'd5;

    logic [2:0] step;

    always_comb begin
        store_go  = acc_rd && (step == LAST_STEP) && (addr == KEY_STORE);
        recall_go = acc_rd && (step == LAST_STEP) && (addr == KEY_RECALL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || acc_wr) begin
            step <= 3'd0;
        end else if (acc_rd) begin
            if (store_go || recall_go)
                step <= 3'd0;
            else if (step < LAST_STEP && addr == key_addr(step))
                step <= step + 3'd1;
            else if (addr == KEY_FIRST)
                step <= 3'd1;
            else
                step <= 3'd0;
        end
    end

    // R6
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n) step <= LAST_STEP);
    // R5
    go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({store_go, recall_go}));
    // R6
    we_low_reset_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_wr |=> (step == 3'd0));
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          cp_store,
    input  logic          cp_recall,
    input  logic [AW-1:0] cp_idx
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] work_q   [DEPTH];
    logic [DW-1:0] shadow_q [DEPTH];

    always_ff @(posedge clk) begin
        if (cp_recall)
            work_q[cp_idx] <= shadow_q[cp_idx];
        else if (wr_en)
            work_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (cp_store)
            shadow_q[cp_idx] <= work_q[cp_idx];
    end

    assign rd_data = work_q[rd_addr];

    // R8
    copy_excl_chk: assert property (@(posedge clk) !(cp_store && cp_recall));
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
    import nvs_pkg::*;
#(
    parameter int ARR_AW      = 6,
    parameter int STORE_TAIL  = 3,
    parameter int RECALL_TAIL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              hsb_n,
    output logic              busy_n
);
    localparam int DEPTH      = 1 << ARR_AW;
    localparam int STORE_CYC  = DEPTH + STORE_TAIL;
    localparam int RECALL_CYC = DEPTH + RECALL_TAIL;
    localparam int MAX_CYC    = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    nvs_state_t        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              dirty;
    logic              from_hw;
    logic              idle, acc_ok, acc_rd, acc_wr, op_last;
    logic              store_go, recall_go;
    logic              cp_store, cp_recall;
    logic [DATA_W-1:0] rd_data;

    assign idle    = (state == ST_IDLE);
    assign acc_ok  = idle && !ce_n && hsb_n;
    assign acc_rd  = acc_ok && we_n;
    assign acc_wr  = acc_ok && !we_n;
    assign op_last = ((state == ST_STORE)  && (cnt == CNT_W'(STORE_CYC - 1))) ||
                     ((state == ST_RECALL) && (cnt == CNT_W'(RECALL_CYC - 1)));

    nvs_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!idle || !hsb_n),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .addr      (addr),
        .store_go  (store_go),
        .recall_go (recall_go)
    );

    nvs_array #(.AW(ARR_AW), .DW(DATA_W)) u_array (
        .clk       (clk),
        .wr_en     (acc_wr),
        .wr_addr   (addr[ARR_AW-1:0]),
        .wr_data   (din),
        .rd_addr   (addr[ARR_AW-1:0]),
        .rd_data   (rd_data),
        .cp_store  (cp_store),
        .cp_recall (cp_recall),
        .cp_idx    (cnt[ARR_AW-1:0])
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!hsb_n)
                    state_nx = dirty ? ST_STORE : ST_HOLD;
                else if (store_go)
                    state_nx = dirty ? ST_STORE : ST_IDLE;
                else if (recall_go)
                    state_nx = ST_RECALL;
            end
            ST_STORE:  if (op_last) state_nx = from_hw ? ST_HOLD : ST_IDLE;
            ST_RECALL: if (op_last) state_nx = ST_IDLE;
            ST_HOLD:   if (hsb_n) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            dirty   <= 1'b0;
            from_hw <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + CNT_W'(1);
            if (idle)
                from_hw <= !hsb_n;
            if (op_last)
                dirty <= 1'b0;
            else if (acc_wr)
                dirty <= 1'b1;
        end
    end

    // Output logic
    always_comb begin
        busy_n    = idle;
        cp_store  = (state == ST_STORE)  && (cnt < CNT_W'(DEPTH));
        cp_recall = (state == ST_RECALL) && (cnt < CNT_W'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= acc_rd && !oe_n;
            dout    <= (acc_rd && !oe_n) ? rd_data : '0;
        end
    end

    // R8
    busy_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !idle |=> !dout_en);
    // R2
    write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_wr |=> dirty);
    // R10
    op_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) op_last |=> !dirty);
    // R9
    clean_store_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && hsb_n && store_go && !dirty) |=> busy_n);
    // R11
    hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !hsb_n) |=> !busy_n);
    // R12
    clean_hsb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !hsb_n && !dirty) |=> (state == ST_HOLD));
endmodule

// File: tb/tb_nvsram_ctrl.sv
`timescale 1ns/1ps
module tb_nvsram_ctrl;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int ST_T = 3;
    localparam int RC_T = 5;
    localparam int STORE_CYC = DEPTH + ST_T;
    localparam int RECALL_CYC = DEPTH + RC_T;

    logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hsb_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0] din = '0, dout;
    logic dout_en, busy_n;
    int checks = 0, fails = 0;
    logic [7:0] q;
    logic qe;

    always #2.5 clk = ~clk;

    nvsram_ctrl #(.ARR_AW(AW), .STORE_TAIL(ST_T), .RECALL_TAIL(RC_T)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .hsb_n(hsb_n), .busy_n(busy_n));

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7) + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One access cycle, starting and ending at a falling edge
    task automatic acc(input logic [12:0] a, input logic w, input logic [7:0] d,
                       input logic oe, input bit gap, output logic [7:0] rq, output logic rqe);
        ce_n = 1'b0; we_n = w; oe_n = oe; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        rq = dout; rqe = dout_en;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        if (gap) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!busy_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic seq_head();
        acc(13'h0000, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1555, 1'b1, 8'h00, 1'b1, 1'b1, q, qe);
        acc(13'h0AAA, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1FFF, 1'b1, 8'h00, 1'b1, 1'b1, q, qe);
        acc(13'h10F0, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
    endtask

    task automatic t_reset();
        chk(busy_n == 1'b1, "R1", "busy_n", busy_n, 1);
        chk(dout_en == 1'b0, "R1", "dout_en", dout_en, 0);
        chk(dout == 8'h00, "R1", "dout", dout, 0);
    endtask

    task automatic t_rw();
        for (int i = 0; i < DEPTH; i++) acc(13'(i), 1'b0, pat(i), 1'b1, 1'b0, q, qe);
        acc(13'h0011, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(qe && q == pat(17), "R3", "read 0x11", q, pat(17));
        acc(13'h1FC5, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(qe && q == pat(5), "R2", "aliased read", q, pat(5));
        acc(13'h0011, 1'b1, 8'h00, 1'b1, 1'b1, q, qe);
        chk(!qe && q == 8'h00, "R3", "oe_n high", qe, 0);
        oe_n = 1'b0; addr = 13'h0011;
        @(posedge clk); @(negedge clk);
        chk(!dout_en, "R3", "ce_n high", dout_en, 0);
        oe_n = 1'b1;
    endtask

    task automatic t_store();
        int n;
        acc(13'h0000, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(qe && q == pat(0), "R4", "seq read data", q, pat(0));
        acc(13'h1555, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(qe && q == pat(21), "R4", "seq read data 2", q, pat(21));
        acc(13'h0AAA, 1'b1, 8'h00, 1'b1, 1'b1, q, qe);
        acc(13'h1FFF, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h10F0, 1'b1, 8'h00, 1'b1, 1'b1, q, qe);
        acc(13'h0F0F, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        count_busy(n);
        chk(n == STORE_CYC, "R7", "store busy length", n, STORE_CYC);
        // R9 R10: flag cleared, second store skipped
        seq_head();
        acc(13'h0F0F, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        chk(busy_n == 1'b1, "R10", "repeat store skipped", busy_n, 1);
        @(negedge clk);
    endtask

    task automatic t_recall();
        int n;
        for (int i = 0; i < DEPTH; i++) acc(13'(i), 1'b0, ~pat(i), 1'b1, 1'b0, q, qe);
        seq_head();
        acc(13'h0F0E, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        acc(13'h0005, 1'b0, 8'h00, 1'b1, 1'b0, q, qe);
        acc(13'h0005, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        chk(!qe, "R8", "read while busy", qe, 0);
        count_busy(n);
        chk(n == RECALL_CYC - 2, "R7", "recall busy length", n, RECALL_CYC - 2);
        n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            acc(13'(i), 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
            if (q != pat(i)) n++;
        end
        chk(n == 0, "R13", "recalled byte mismatches", n, 0);
        acc(13'h0005, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(q == pat(5), "R8", "write while busy dropped", q, pat(5));
        // R9: flag clear after recall, store skipped
        seq_head();
        acc(13'h0F0F, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        chk(busy_n == 1'b1, "R9", "clean store skipped", busy_n, 1);
        @(negedge clk);
    endtask

    task automatic t_matcher();
        int n;
        acc(13'h0001, 1'b0, 8'h99, 1'b1, 1'b1, q, qe);
        acc(13'h0000, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1555, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h0AAA, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1FFF, 1'b0, 8'h77, 1'b1, 1'b1, q, qe);
        acc(13'h10F0, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h0F0F, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        chk(busy_n == 1'b1, "R6", "we_n low breaks sequence", busy_n, 1);
        @(negedge clk);
        acc(13'h0000, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1555, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h0AAB, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1FFF, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h10F0, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h0F0F, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        chk(busy_n == 1'b1, "R6", "wrong address breaks sequence", busy_n, 1);
        @(negedge clk);
        acc(13'h0000, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        acc(13'h1555, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        seq_head();
        acc(13'h0F0E, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        count_busy(n);
        chk(n == RECALL_CYC, "R5", "restart at 0x0000 then recall", n, RECALL_CYC);
        acc(13'h0001, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(q == pat(1), "R6", "recall undid writes", q, pat(1));
    endtask

    task automatic t_hsb();
        int n;
        acc(13'h0002, 1'b0, 8'h5A, 1'b1, 1'b1, q, qe);
        hsb_n = 1'b0;
        @(negedge clk);
        n = 0;
        for (int i = 0; i < STORE_CYC + 3; i++) begin
            if (!busy_n) n++;
            @(negedge clk);
        end
        chk(n == STORE_CYC + 3, "R11", "busy held while hsb_n low", n, STORE_CYC + 3);
        hsb_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R11", "release after hsb_n high", busy_n, 1);
        acc(13'h0002, 1'b0, 8'h11, 1'b1, 1'b1, q, qe);
        seq_head();
        acc(13'h0F0E, 1'b1, 8'h00, 1'b0, 1'b0, q, qe);
        count_busy(n);
        acc(13'h0002, 1'b1, 8'h00, 1'b0, 1'b1, q, qe);
        chk(q == 8'h5A, "R11", "hardware store saved byte", q, 8'h5A);
        hsb_n = 1'b0;
        @(negedge clk);
        chk(busy_n == 1'b0, "R12", "clean hold entered", busy_n, 0);
        hsb_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R12", "no copy period", busy_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_store();
        t_recall();
        t_matcher();
        t_hsb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule